// File: doc/BRIEF.md
# Restart-Opcode Interrupt Responder

This block sits between up to eight peripheral interrupt sources and an 8-bit processor that has a single interrupt input. It captures each source as a rising edge, keeps one pending bit per line, and raises the processor's interrupt request while any bit is pending and the processor's interrupt-enable output is high.

When the processor fetches its interrupt instruction, it marks that fetch with an acknowledge status flag while the read strobe is active. The block then drives a complete one-byte restart instruction onto the data bus. The byte has the form `11nnn111`, where `nnn` is the index of the winning line, so control passes to address `nnn*8`. The winning line is the lowest-numbered pending line at the moment the acknowledge read begins. Its pending bit is cleared when that read ends.

Top module: `irq_restart_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cpu_int`, `data_oe` and `data_out` are all zero, and every pending bit is cleared.
- R2: A line becomes pending only on a low-to-high change of its request input, sampled at the clock. A line held high does not become pending again until it has been seen low and then high.
- R3: `cpu_int` is a register. After each clock edge it shows whether any line was pending and `int_enable` was high just before that edge.
- R4: `data_oe` is high in the cycle after a clock edge at which `rd_strobe` and `ack_flag` were both high. Either signal alone never drives the bus.
- R5: The driven byte is `{2'b11, nnn, 3'b111}`, where `nnn` is the lowest-numbered line pending when the acknowledge read starts (line 0 wins). If no line is pending, the byte is 8'hFF.
- R6: The vector is latched when the acknowledge read starts. A request that arrives during the read does not change the driven byte.
- R7: When the acknowledge read ends, the pending bit of the served line clears. All other pending bits remain.
- R8: If a new rising edge on the served line is captured at the same clock edge where its pending bit would clear, the line stays pending.
- R9: `data_out` is 8'h00 whenever `data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | NUM_LINES | Interrupt request lines, edge-captured, line 0 highest priority |
| ack_flag | input | 1 | Latched interrupt-acknowledge status flag from the processor |
| rd_strobe | input | 1 | Processor read strobe |
| int_enable | input | 1 | Processor's interrupt-enable output |
| cpu_int | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Restart opcode for the data bus |
| data_oe | output | 1 | Data bus drive enable |

## Verification
A request edge sets its pending bit at the first clock edge where the line is sampled high. `cpu_int` follows at the next edge, so it is due two edges after the line rises. The restart byte and `data_oe` appear one edge after the read strobe and the acknowledge flag are both high. The served pending bit clears at the edge where the read is first seen low, and `cpu_int` reflects that clear one edge later. The bench changes inputs on falling edges, advances a counted number of rising edges, and samples on the following falling edge. Each check is therefore made exactly in the cycle worked out above for it.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;
  localparam int VEC_W  = 3;
  localparam int BYTE_W = 8;

  typedef logic [VEC_W-1:0] vec_idx_t;

  // Restart opcode: 11 nnn 111, target address nnn*8
  function automatic logic [BYTE_W-1:0] rst_opcode(input vec_idx_t idx);
    return {2'b11, idx, 3'b111};
  endfunction
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] req_q;
  logic [NUM_LINES-1:0] rise;

  assign rise = req & ~req_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        req_q[i] <= req[i];
        if (rise[i])
          pend[i] <= 1'b1;
        else if (clr[i])
          pend[i] <= 1'b0;
      end
    end

    // R2
    pend_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[i]) |-> $past(req[i]));

    // R7
    clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !rise[i]) |=> !pend[i]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && rise[i]) |=> pend[i]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_rst_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0] pend,
  output vec_idx_t             win_idx,
  output logic                 win_any
);
  always_comb begin
    win_idx = vec_idx_t'(2**VEC_W - 1);
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend[i]) win_idx = vec_idx_t'(i);
    end
  end

  assign win_any = |pend;
endmodule

// File: rtl/irq_ack_ctl.sv
module irq_ack_ctl
  import irq_rst_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_strobe,
  input  logic                 ack_flag,
  input  vec_idx_t             win_idx,
  input  logic                 win_any,
  output logic [BYTE_W-1:0]    data_out,
  output logic                 data_oe,
  output logic [NUM_LINES-1:0] clr_mask
);
  logic     acc;
  logic     start;
  logic     finish;
  vec_idx_t sel_idx;
  logic     sel_any;

  assign acc    = rd_strobe & ack_flag;
  assign start  = acc & ~data_oe;
  assign finish = data_oe & ~acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
      sel_idx  <= '0;
      sel_any  <= 1'b0;
    end else begin
      data_oe <= acc;
      if (start) begin
        sel_idx  <= win_idx;
        sel_any  <= win_any;
        data_out <= rst_opcode(win_any ? win_idx : vec_idx_t'(2**VEC_W - 1));
      end else if (!acc) begin
        data_out <= '0;
      end
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_clr
    assign clr_mask[i] = finish & sel_any & (sel_idx == vec_idx_t'(i));
  end

  // R4
  oe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(rd_strobe && ack_flag));

  // R5
  opcode_shape_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (data_out[7:6] == 2'b11 && data_out[2:0] == 3'b111));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (data_oe && $past(data_oe)) |-> $stable(data_out));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));
endmodule

// File: rtl/irq_restart_unit.sv
module irq_restart_unit
  import irq_rst_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 ack_flag,
  input  logic                 rd_strobe,
  input  logic                 int_enable,
  output logic                 cpu_int,
  output logic [7:0]           data_out,
  output logic                 data_oe
);
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] clr_mask;
  vec_idx_t             win_idx;
  logic                 win_any;

  irq_edge_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk  (clk),
    .rst  (rst),
    .req  (irq_req),
    .clr  (clr_mask),
    .pend (pend)
  );

  irq_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .pend    (pend),
    .win_idx (win_idx),
    .win_any (win_any)
  );

  irq_ack_ctl #(.NUM_LINES(NUM_LINES)) u_ack (
    .clk       (clk),
    .rst       (rst),
    .rd_strobe (rd_strobe),
    .ack_flag  (ack_flag),
    .win_idx   (win_idx),
    .win_any   (win_any),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .clr_mask  (clr_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_int <= 1'b0;
    else     cpu_int <= win_any & int_enable;
  end

  // R3
  int_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_int |-> ($past(int_enable) && $past(|pend)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cpu_int && !data_oe && data_out == 8'h00));
endmodule

// File: tb/irq_restart_unit_tb.sv
module irq_restart_unit_tb;
  typedef struct packed {
    logic [7:0] pat;
    logic       en;
    logic       exp_int;
    logic [7:0] exp_op;
    logic       exp_int_after;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 1'b1, 1'b1, 8'hC7, 1'b0},
    '{8'h80, 1'b1, 1'b1, 8'hFF, 1'b0},
    '{8'h28, 1'b1, 1'b1, 8'hDF, 1'b1},
    '{8'hF0, 1'b1, 1'b1, 8'hE7, 1'b1},
    '{8'h06, 1'b0, 1'b0, 8'hCF, 1'b0},
    '{8'h00, 1'b1, 1'b0, 8'hFF, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_req = '0;
  logic       ack_flag = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       int_enable = 1'b0;
  logic       cpu_int;
  logic [7:0] data_out;
  logic       data_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  irq_restart_unit #(.NUM_LINES(8)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .ack_flag   (ack_flag),
    .rd_strobe  (rd_strobe),
    .int_enable (int_enable),
    .cpu_int    (cpu_int),
    .data_out   (data_out),
    .data_oe    (data_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_req = '0; rd_strobe = 1'b0; ack_flag = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    step(1);
    do_reset();
    // R1: reset state
    check("R1 cpu_int", {7'b0, cpu_int}, 8'h00);
    check("R1 data_oe", {7'b0, data_oe}, 8'h00);
    check("R1 data_out", data_out, 8'h00);

    // Vector table: R3 R5 R7 R9
    for (int v = 0; v < NV; v++) begin
      do_reset();
      int_enable = VECS[v].en;
      irq_req = VECS[v].pat;
      step(1);
      irq_req = '0;
      step(1);
      check("R3 int after request", {7'b0, cpu_int}, {7'b0, VECS[v].exp_int});
      rd_strobe = 1'b1; ack_flag = 1'b1;
      step(1);
      check("R4 oe during ack", {7'b0, data_oe}, 8'h01);
      check("R5 opcode", data_out, VECS[v].exp_op);
      rd_strobe = 1'b0; ack_flag = 1'b0;
      step(1);
      check("R9 oe off", {7'b0, data_oe}, 8'h00);
      check("R9 data zero", data_out, 8'h00);
      step(1);
      check("R7 int after clear", {7'b0, cpu_int}, {7'b0, VECS[v].exp_int_after});
    end

    // R1: reset drops a pending request
    do_reset();
    int_enable = 1'b1;
    irq_req = 8'h10; step(1); irq_req = '0; step(1);
    check("R1 pre-reset int", {7'b0, cpu_int}, 8'h01);
    do_reset(); step(1);
    check("R1 pending cleared by reset", {7'b0, cpu_int}, 8'h00);

    // R2: held line does not retrigger
    do_reset();
    int_enable = 1'b1;
    irq_req = 8'h04; step(2);
    check("R2 int on edge", {7'b0, cpu_int}, 8'h01);
    rd_strobe = 1'b1; ack_flag = 1'b1; step(1);
    check("R2 opcode line2", data_out, 8'hD7);
    rd_strobe = 1'b0; ack_flag = 1'b0; step(2);
    check("R2 held no retrigger", {7'b0, cpu_int}, 8'h00);
    step(2);
    check("R2 still no retrigger", {7'b0, cpu_int}, 8'h00);
    irq_req = 8'h00; step(1);
    irq_req = 8'h04; step(2);
    check("R2 new edge retriggers", {7'b0, cpu_int}, 8'h01);

    // R4: read without ack, ack without read
    rd_strobe = 1'b1; ack_flag = 1'b0; step(1);
    check("R4 rd alone oe", {7'b0, data_oe}, 8'h00);
    check("R4 rd alone data", data_out, 8'h00);
    rd_strobe = 1'b0; ack_flag = 1'b1; step(1);
    check("R4 ack alone oe", {7'b0, data_oe}, 8'h00);
    ack_flag = 1'b0; step(2);
    check("R4 nothing cleared", {7'b0, cpu_int}, 8'h01);

    // R3: enable gating
    int_enable = 1'b0; step(1);
    check("R3 disabled", {7'b0, cpu_int}, 8'h00);
    int_enable = 1'b1; step(1);
    check("R3 re-enabled", {7'b0, cpu_int}, 8'h01);

    // R6: vector latched at start of read
    rd_strobe = 1'b1; ack_flag = 1'b1; step(1);
    check("R6 start opcode", data_out, 8'hD7);
    irq_req = 8'h05; step(1);
    check("R6 held during read", data_out, 8'hD7);
    step(1);
    check("R6 still held", data_out, 8'hD7);
    rd_strobe = 1'b0; ack_flag = 1'b0; irq_req = 8'h00; step(1);
    rd_strobe = 1'b1; ack_flag = 1'b1; step(1);
    check("R6 late line served next", data_out, 8'hC7);
    rd_strobe = 1'b0; ack_flag = 1'b0; step(2);
    check("R7 all served", {7'b0, cpu_int}, 8'h00);

    // R8: new edge coincides with clear
    do_reset();
    int_enable = 1'b1;
    irq_req = 8'h20; step(1); irq_req = '0; step(1);
    rd_strobe = 1'b1; ack_flag = 1'b1; step(1);
    check("R8 first opcode", data_out, 8'hEF);
    rd_strobe = 1'b0; ack_flag = 1'b0; irq_req = 8'h20; step(1);
    irq_req = '0; step(1);
    check("R8 still pending", {7'b0, cpu_int}, 8'h01);
    rd_strobe = 1'b1; ack_flag = 1'b1; step(1);
    check("R8 served again", data_out, 8'hEF);
    rd_strobe = 1'b0; ack_flag = 1'b0; step(2);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule